// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This sequencer drives the memory side of a load-multiple or store-multiple operation. A request supplies a base address, a register selection mask, one of four addressing modes, a load/store select and a writeback enable. The block then steps through the selected registers one per accepted beat. On each beat it presents a word address and a register index on a valid/ready interface. After the last beat it raises a one-cycle completion pulse. At that pulse it also gives the updated base value when writeback is enabled.

All four modes share a single upward address walk. The lowest-numbered selected register always goes to the lowest address, so descending modes differ from ascending ones only in where the walk begins and in the sign of the writeback adjustment. Stack idioms map directly onto the modes. A descending-stack push is a decrement-before store, and the matching pop is an increment-after load. An ascending push into an empty slot is an increment-after store. A request runs to completion once accepted and cannot be cut short.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, start_ready is 1 and mem_valid, done and wb_valid are 0.
- R2: The first beat address depends on mode, where n is the number of set bits in reg_mask. Mode 2'b00 (increment-after) starts at base. Mode 2'b01 (increment-before) starts at base+4. Mode 2'b10 (decrement-after) starts at base-4n+4. Mode 2'b11 (decrement-before) starts at base-4n.
- R3: Each selected register is transferred exactly once, in ascending index order. Each accepted beat's address is 4 above the previous one.
- R4: While mem_valid is 1 and mem_ready is 0, mem_addr and mem_reg hold their values.
- R5: mem_write is 1 on every beat of a store (is_load=0) and 0 on every beat of a load (is_load=1).
- R6: done is a single-cycle pulse. It occurs in the cycle after the last accepted beat. With mem_ready held at 1, this is the (n+1)th cycle after the request is accepted.
- R7: With wb_en=1, wb_valid is 1 together with done. wb_addr then equals base+4n for modes 2'b00/2'b01 and base-4n for modes 2'b10/2'b11.
- R8: With wb_en=0, wb_valid stays 0 and wb_addr equals the unchanged base at done.
- R9: An empty reg_mask produces no beat and raises done in the first cycle after acceptance.
- R10: start_ready is 0 from acceptance through the done cycle, and is 1 again the cycle after. start_valid and all request inputs are ignored while start_ready is 0.
- R11: All address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Sequencer idle, request accepted when start_valid is 1 |
| base_addr | input | ADDR_W | Base address of the transfer |
| reg_mask | input | NREG | One bit per register to transfer |
| mode | input | 2 | 00 inc-after, 01 inc-before, 10 dec-after, 11 dec-before |
| is_load | input | 1 | 1 load, 0 store |
| wb_en | input | 1 | Report updated base |
| mem_valid | output | 1 | Beat presented |
| mem_ready | input | 1 | Beat accepted by memory/register file |
| mem_write | output | 1 | Beat is a store |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_reg | output | $clog2(NREG) | Register index of the beat |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | wb_addr is to be written to the base register |
| wb_addr | output | ADDR_W | Updated base (or unchanged base) at done |

## Verification
Several properties are checked on every cycle. The assertions check the +4 address step between accepted beats and the strictly rising register index. They check that a stalled beat stays stable and that done is a single pulse. They check that beats and done never overlap, that the beat count matches the popcount captured at acceptance, and the empty-list and no-writeback rules. Other behaviour can only be shown by the bench's scenarios. These are the mode-dependent start addresses and writeback values, the data a load actually picks up from a modelled memory, the wraparound of a full list below a small base, and the fact that a second request offered mid-transfer changes nothing.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [NREG-1:0]   reg_mask,
  input  logic [1:0]        mode,
  input  logic              is_load,
  input  logic              wb_en,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  mem_reg,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

  state_t            st_q;
  logic [NREG-1:0]   pend_q;
  logic [ADDR_W-1:0] addr_q, wb_q;
  logic              wb_en_q, store_q;

  logic [CNT_W-1:0]  sel_cnt;
  logic [ADDR_W-1:0] span, first_addr, new_base;
  logic [IDX_W-1:0]  low_idx;
  logic              last_beat;

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NREG; i++) sel_cnt = sel_cnt + CNT_W'(reg_mask[i]);
  end

  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (pend_q[i]) low_idx = IDX_W'(i);
  end

  assign span = ADDR_W'(sel_cnt) << 2;

  always_comb begin
    case (mode)
      2'b00:   first_addr = base_addr;
      2'b01:   first_addr = base_addr + ADDR_W'(4);
      2'b10:   first_addr = base_addr - span + ADDR_W'(4);
      default: first_addr = base_addr - span;
    endcase
  end

  assign new_base  = mode[1] ? base_addr - span : base_addr + span;
  assign last_beat = (pend_q & (pend_q - NREG'(1))) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      wb_en_q <= 1'b0;
      store_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_valid) begin
          pend_q  <= reg_mask;
          addr_q  <= first_addr;
          wb_q    <= wb_en ? new_base : base_addr;
          wb_en_q <= wb_en;
          store_q <= !is_load;
          st_q    <= (reg_mask == '0) ? S_DONE : S_RUN;
        end
        S_RUN: if (mem_ready) begin
          pend_q <= pend_q & (pend_q - NREG'(1));
          addr_q <= addr_q + ADDR_W'(4);
          if (last_beat) st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign start_ready = st_q == S_IDLE;
  assign mem_valid   = st_q == S_RUN;
  assign mem_write   = mem_valid && store_q;
  assign mem_addr    = addr_q;
  assign mem_reg     = low_idx;
  assign done        = st_q == S_DONE;
  assign wb_valid    = done && wb_en_q;
  assign wb_addr     = wb_q;

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic [ADDR_W-1:0] base_addr,
  input logic [NREG-1:0]   reg_mask,
  input logic [1:0]        mode,
  input logic              is_load,
  input logic              wb_en,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [IDX_W-1:0]  mem_reg,
  input logic              done,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_addr
);

  logic [CNT_W-1:0]  hs_cnt, exp_cnt;
  logic [ADDR_W-1:0] base_q;
  logic              accept, beat;

  assign accept = start_valid && start_ready;
  assign beat   = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt  <= '0;
      exp_cnt <= '0;
      base_q  <= '0;
    end else if (accept) begin
      hs_cnt  <= '0;
      exp_cnt <= CNT_W'($countones(reg_mask));
      base_q  <= base_addr;
    end else if (beat) begin
      hs_cnt <= hs_cnt + CNT_W'(1);
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (!mem_valid || mem_addr == $past(mem_addr) + ADDR_W'(4))); // R3
  AST_IDX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (!mem_valid || mem_reg > $past(mem_reg))); // R3
  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hs_cnt == exp_cnt); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_reg)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && start_ready); // R6
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !start_ready && !done); // R10
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done); // R7
  AST_NO_WB_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wb_valid |-> wb_addr == base_q); // R8
  AST_EMPTY_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && reg_mask == '0 |=> done && !mem_valid); // R9

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (.*);

// File: tb/test_blk_xfer_seq.sv
`timescale 1ns/1ps
module test_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic [1:0]  mode = '0;
  logic        is_load = 1'b0;
  logic        wb_en = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_reg;
  logic        done;
  logic        wb_valid;
  logic [31:0] wb_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] rec_addr [16];
  logic [3:0]  rec_idx  [16];
  logic        rec_wr   [16];
  int          nrec, done_k;
  logic        got_wbv, ready_after;
  logic [31:0] got_wba;

  always #2 clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (.*);

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_at(input logic [31:0] a);
    return 32'd10 * ((a - 32'h10) / 4 + 1);
  endfunction

  task automatic run_xfer(input logic [31:0] base, input logic [15:0] mask, input logic [1:0] md,
                          input logic ld, input logic wb, input logic [7:0] pat, input bit poke);
    nrec = 0; done_k = -1;
    @(negedge clk);
    base_addr = base; reg_mask = mask; mode = md; is_load = ld; wb_en = wb; start_valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 200; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == 1) begin
        start_valid = 1'b1; base_addr = 32'hDEAD0000; reg_mask = 16'hFFFF; mode = 2'b11; is_load = ~ld;
        check(start_ready == 1'b0, "R10 busy start_ready", 32'(start_ready), 32'd0);
      end else start_valid = 1'b0;
      if (done) begin
        done_k = k; got_wbv = wb_valid; got_wba = wb_addr;
        break;
      end
      mem_ready = pat[k % 8];
      #1;
      if (mem_valid && mem_ready && nrec < 16) begin
        rec_addr[nrec] = mem_addr; rec_idx[nrec] = mem_reg; rec_wr[nrec] = mem_write;
        nrec++;
      end
    end
    mem_ready = 1'b0; start_valid = 1'b0;
    @(negedge clk);
    ready_after = start_ready;
  endtask

  task automatic verify(input string req, input logic [31:0] base, input logic [15:0] mask,
                        input logic [1:0] md, input logic ld, input logic wb, input bit full_ready);
    int n = $countones(mask);
    logic [31:0] span = 32'(n) * 4;
    logic [31:0] st;
    int pos = 0;
    case (md)
      2'b00: st = base;
      2'b01: st = base + 4;
      2'b10: st = base - span + 4;
      default: st = base - span;
    endcase
    check(nrec == n, {req, " R3 beat count"}, 32'(nrec), 32'(n));
    for (int r = 0; r < 16; r++) begin
      if (mask[r] && pos < nrec) begin
        check(rec_idx[pos] == 4'(r), {req, " R3 register order"}, 32'(rec_idx[pos]), 32'(r));
        check(rec_addr[pos] == st + 32'(pos) * 4, {req, " R2 R3 beat address"},
              rec_addr[pos], st + 32'(pos) * 4);
        check(rec_wr[pos] == !ld, {req, " R5 write flag"}, 32'(rec_wr[pos]), 32'(!ld));
        pos++;
      end
    end
    if (full_ready) check(done_k == n, {req, " R6 done timing"}, 32'(done_k), 32'(n));
    else check(done_k >= n, {req, " R6 done after beats"}, 32'(done_k), 32'(n));
    if (wb) begin
      check(got_wbv == 1'b1, {req, " R7 wb_valid"}, 32'(got_wbv), 32'd1);
      check(got_wba == (md[1] ? base - span : base + span), {req, " R7 wb_addr"},
            got_wba, md[1] ? base - span : base + span);
    end else begin
      check(got_wbv == 1'b0, {req, " R8 wb_valid"}, 32'(got_wbv), 32'd0);
      check(got_wba == base, {req, " R8 base unchanged"}, got_wba, base);
    end
    check(ready_after == 1'b1, {req, " R10 ready after done"}, 32'(ready_after), 32'd1);
  endtask

  task automatic check_loads(input string req, input logic [31:0] v0, input logic [31:0] v1, input logic [31:0] v2);
    logic [31:0] ev [3];
    ev[0] = v0; ev[1] = v1; ev[2] = v2;
    for (int i = 0; i < 3; i++)
      if (i < nrec) check(mem_at(rec_addr[i]) == ev[i], {req, " R2 loaded word"}, mem_at(rec_addr[i]), ev[i]);
  endtask

  task automatic t_reset();
    #1;
    check(start_ready == 1'b1, "R1 start_ready", 32'(start_ready), 32'd1);
    check(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 32'd0);
    check(done == 1'b0, "R1 done", 32'(done), 32'd0);
    check(wb_valid == 1'b0, "R1 wb_valid", 32'(wb_valid), 32'd0);
  endtask

  task automatic t_modes();
    run_xfer(32'h10, 16'h000E, 2'b00, 1'b1, 1'b1, 8'hFF, 1'b0);
    verify("IA", 32'h10, 16'h000E, 2'b00, 1'b1, 1'b1, 1'b1); check_loads("IA", 10, 20, 30);
    check(got_wba == 32'h1C, "R7 IA writeback", got_wba, 32'h1C);
    run_xfer(32'h10, 16'h000E, 2'b01, 1'b1, 1'b1, 8'hFF, 1'b0);
    verify("IB", 32'h10, 16'h000E, 2'b01, 1'b1, 1'b1, 1'b1); check_loads("IB", 20, 30, 40);
    check(got_wba == 32'h1C, "R7 IB writeback", got_wba, 32'h1C);
    run_xfer(32'h24 + 32'h4, 16'h000E, 2'b10, 1'b1, 1'b1, 8'hFF, 1'b0);
    run_xfer(32'h24, 16'h000E, 2'b10, 1'b1, 1'b1, 8'hFF, 1'b0);
    verify("DA", 32'h24, 16'h000E, 2'b10, 1'b1, 1'b1, 1'b1); check_loads("DA", 40, 50, 60);
    check(got_wba == 32'h18, "R7 DA writeback", got_wba, 32'h18);
    run_xfer(32'h24, 16'h000E, 2'b11, 1'b1, 1'b1, 8'hFF, 1'b0);
    verify("DB", 32'h24, 16'h000E, 2'b11, 1'b1, 1'b1, 1'b1); check_loads("DB", 30, 40, 50);
    check(got_wba == 32'h18, "R7 DB writeback", got_wba, 32'h18);
  endtask

  task automatic t_push_store();
    run_xfer(32'h100, 16'h4010, 2'b11, 1'b0, 1'b1, 8'hFF, 1'b0);
    verify("push", 32'h100, 16'h4010, 2'b11, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_no_wb();
    run_xfer(32'h40, 16'h0301, 2'b01, 1'b1, 1'b0, 8'hFF, 1'b0);
    verify("nowb", 32'h40, 16'h0301, 2'b01, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_stall();
    run_xfer(32'h200, 16'h8421, 2'b00, 1'b0, 1'b1, 8'b0110_1001, 1'b0);
    verify("stall R4", 32'h200, 16'h8421, 2'b00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_empty();
    run_xfer(32'h300, 16'h0000, 2'b11, 1'b1, 1'b1, 8'hFF, 1'b0);
    verify("empty", 32'h300, 16'h0000, 2'b11, 1'b1, 1'b1, 1'b1);
    check(done_k == 0, "R9 immediate done", 32'(done_k), 32'd0);
    check(got_wba == 32'h300, "R9 base kept", got_wba, 32'h300);
  endtask

  task automatic t_wrap();
    run_xfer(32'h20, 16'hFFFF, 2'b11, 1'b0, 1'b1, 8'hFF, 1'b0);
    verify("wrap", 32'h20, 16'hFFFF, 2'b11, 1'b0, 1'b1, 1'b1);
    check(rec_addr[0] == 32'hFFFF_FFE0, "R11 wrapped start", rec_addr[0], 32'hFFFF_FFE0);
    check(got_wba == 32'hFFFF_FFE0, "R11 wrapped writeback", got_wba, 32'hFFFF_FFE0);
  endtask

  task automatic t_busy_poke();
    run_xfer(32'h80, 16'h00F0, 2'b10, 1'b1, 1'b1, 8'hFF, 1'b1);
    verify("poke R10", 32'h80, 16'h00F0, 2'b10, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_modes();
    t_push_store();
    t_no_wb();
    t_stall();
    t_empty();
    t_wrap();
    t_busy_poke();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule